// File: doc/BRIEF.md
# PCI Target Command Decoder and Burst Address Tracker

This block sits on the target side of a 32-bit multiplexed address/data bus of the PCI kind. In the clock that carries the address phase, it samples the command nibble and the address word. From these it decides whether the transaction is claimed and whether it is a read or a write. It also decides whether the access goes to memory space or to the 256-byte configuration space. Several memory command flavours are treated as plain reads or plain writes. Reserved codes, dual-address cycles and all other codes are never claimed.

After a claimed address phase, the block holds the current dword address. It steps that address once for every completed data phase until the transaction ends. The two low address bits of a memory command choose the burst ordering. One encoding is plain linear. One is cache-wrap, which is flagged to the user but still advances linearly. The two remaining encodings are reserved, so such an access is flagged and left unclaimed. An even-parity bit over the address word and the command nibble is presented one clock after the address phase.

Top module: `pci_tgt_cmd_track`

## Requirements
- R1: Commands 4'b0110, 4'b1100 and 4'b1110 with ad[0]=0 are claimed as memory reads: one clock after the address phase, claim=1, is_read=1 and is_config=0.
- R2: Commands 4'b0111 and 4'b1111 with ad[0]=0 are claimed as memory writes: claim=1, is_read=0 and is_config=0.
- R3: Command 4'b1010 (configuration read) and command 4'b1011 (configuration write) are claimed whatever ad[1:0] holds. For them, is_config=1, is_read equals the inverse of cbe[0], wrap_mode=0, reserved_order=0, and cur_addr equals ad[7:2] zero-extended.
- R4: Command 4'b1001 (reserved), command 4'b1101 (dual address cycle) and every other code not listed in R1 to R3 are not claimed. After such a phase, claim, is_read, is_config, wrap_mode, reserved_order and cur_addr are all 0.
- R5: For a memory command, ad[1:0]=2'b00 gives wrap_mode=0 and ad[1:0]=2'b10 gives wrap_mode=1, and both are claimed. ad[1:0]=2'b01 or 2'b11 gives reserved_order=1 with claim=0 and every other output except addr_par at 0.
- R6: A claimed memory access loads cur_addr with ad[31:2]. Each clock with phase_done=1 adds one to cur_addr, modulo 2^30, in both linear and cache-wrap order.
- R7: A claimed configuration access steps only cur_addr[7:2], modulo 64, on each phase_done. The upper bits stay 0.
- R8: cur_addr holds its value in clocks without phase_done, and phase_done has no effect while claim=0.
- R9: A clock with xfer_end=1 and addr_valid=0 clears claim, is_read, is_config, wrap_mode, reserved_order, cur_addr and addr_par. When addr_valid=1 in the same clock, the new address phase wins.
- R10: addr_par equals the XOR of all bits of ad[31:0] and cbe[3:0], sampled in the address phase. It appears one clock later and is held until xfer_end or the next address phase.
- R11: While rst_n=0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Current clock is an address phase |
| ad | input | 32 | Multiplexed address/data word |
| cbe | input | 4 | Command nibble during the address phase |
| phase_done | input | 1 | A data phase completed in this clock |
| xfer_end | input | 1 | Transaction finished |
| claim | output | 1 | Transaction is accepted by this target |
| is_read | output | 1 | Accepted transaction is a read |
| is_config | output | 1 | Accepted transaction targets configuration space |
| cur_addr | output | 30 | Dword address of the current data phase |
| wrap_mode | output | 1 | Cache-wrap ordering was requested |
| reserved_order | output | 1 | Memory access used a reserved ordering encoding |
| addr_par | output | 1 | Even parity of the address phase |

## Verification
The bound checker watches several rules on every clock. It checks the one-step advance of the memory and configuration counters, that the counter holds when no data phase completes, and that xfer_end clears the outputs. It also checks the parity delay, that reserved and dual-address codes are never claimed, and that a reserved ordering is never claimed. The full decode table is covered only by the bench's sweep over all sixteen commands and four low-bit patterns. The same holds for counter wraparound at the top of memory space and at the 256-byte configuration boundary, for the same-clock priority of a new address phase over xfer_end, and for phase strobes sent while nothing is claimed.

// File: rtl/pci_tgt_cmd_track.sv
module pci_tgt_cmd_track #(
  parameter int AD_W      = 32,
  parameter int CFG_IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_valid,
  input  logic [AD_W-1:0] ad,
  input  logic [3:0]      cbe,
  input  logic            phase_done,
  input  logic            xfer_end,
  output logic            claim,
  output logic            is_read,
  output logic            is_config,
  output logic [AD_W-1:2] cur_addr,
  output logic            wrap_mode,
  output logic            reserved_order,
  output logic            addr_par
);
  localparam int DW_W  = AD_W - 2;
  localparam int CFG_H = CFG_IDX_W + 1;

  logic mem_rd, mem_wr, mem, cfg, take;
  logic [AD_W-1:2] load_addr;

  assign mem_rd = (cbe == 4'b0110) | (cbe == 4'b1100) | (cbe == 4'b1110);
  assign mem_wr = (cbe == 4'b0111) | (cbe == 4'b1111);
  assign mem    = mem_rd | mem_wr;
  assign cfg    = (cbe[3:1] == 3'b101);
  assign take   = (mem & ~ad[0]) | cfg;

  always_comb begin
    if (!take)
      load_addr = '0;
    else if (cfg)
      load_addr = {{(DW_W-CFG_IDX_W){1'b0}}, ad[CFG_H:2]};
    else
      load_addr = ad[AD_W-1:2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (xfer_end && !addr_valid)) begin
      claim          <= 1'b0;
      is_read        <= 1'b0;
      is_config      <= 1'b0;
      cur_addr       <= '0;
      wrap_mode      <= 1'b0;
      reserved_order <= 1'b0;
      addr_par       <= 1'b0;
    end else if (addr_valid) begin
      claim          <= take;
      is_read        <= take & (mem_rd | (cfg & ~cbe[0]));
      is_config      <= cfg;
      cur_addr       <= load_addr;
      wrap_mode      <= mem & (ad[1:0] == 2'b10);
      reserved_order <= mem & ad[0];
      addr_par       <= ^{ad, cbe};
    end else if (phase_done && claim) begin
      if (is_config)
        cur_addr[CFG_H:2] <= cur_addr[CFG_H:2] + 1'b1;
      else
        cur_addr <= cur_addr + 1'b1;
    end
  end
endmodule

module pci_tgt_cmd_track_chk #(
  parameter int AD_W      = 32,
  parameter int CFG_IDX_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            addr_valid,
  input logic [AD_W-1:0] ad,
  input logic [3:0]      cbe,
  input logic            phase_done,
  input logic            xfer_end,
  input logic            claim,
  input logic            is_read,
  input logic            is_config,
  input logic [AD_W-1:2] cur_addr,
  input logic            wrap_mode,
  input logic            reserved_order,
  input logic            addr_par
);
  localparam int CFG_H = CFG_IDX_W + 1;

  a_r6_mem_step: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !is_config && phase_done && !addr_valid && !xfer_end)
    |=> (cur_addr == $past(cur_addr) + 1'b1));

  a_r7_cfg_step: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && is_config && phase_done && !addr_valid && !xfer_end)
    |=> (cur_addr[CFG_H:2] == CFG_IDX_W'($past(cur_addr[CFG_H:2]) + 1'b1)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_done && !addr_valid && !xfer_end) |=> $stable(cur_addr));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !addr_valid)
    |=> (!claim && !wrap_mode && !reserved_order && cur_addr == '0 && !addr_par));

  a_r10_parity: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> (addr_par == $past(^{ad, cbe})));

  a_r4_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && (cbe == 4'b1001 || cbe == 4'b1101)) |=> !claim);

  a_r5_rsv_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_order |-> (!claim && !is_read && !is_config));
endmodule

bind pci_tgt_cmd_track pci_tgt_cmd_track_chk #(.AD_W(AD_W), .CFG_IDX_W(CFG_IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .ad(ad), .cbe(cbe),
  .phase_done(phase_done), .xfer_end(xfer_end), .claim(claim), .is_read(is_read),
  .is_config(is_config), .cur_addr(cur_addr), .wrap_mode(wrap_mode),
  .reserved_order(reserved_order), .addr_par(addr_par));

// File: tb/test_pci_tgt_cmd_track.sv
module test_pci_tgt_cmd_track;
  logic clk = 1'b0, rst_n = 1'b0, addr_valid = 1'b0, phase_done = 1'b0, xfer_end = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic claim, is_read, is_config, wrap_mode, reserved_order, addr_par;
  logic [31:2] cur_addr;
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  pci_tgt_cmd_track i_pci_tgt_cmd_track (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [3:0] c, input logic [31:0] a, input logic endt);
    @(negedge clk);
    addr_valid = 1'b1; cbe = c; ad = a; xfer_end = endt;
    @(negedge clk);
    addr_valid = 1'b0; xfer_end = 1'b0;
  endtask

  task automatic phases(input int n);
    phase_done = 1'b1;
    repeat (n) @(negedge clk);
    phase_done = 1'b0;
  endtask

  task automatic end_xfer();
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
  endtask

  task automatic expect_phase(input string tag, input logic [3:0] c, input logic [31:0] a);
    logic mr, mw, m, cf, tk;
    logic [29:0] ea;
    mr = (c == 4'h6) || (c == 4'hC) || (c == 4'hE);
    mw = (c == 4'h7) || (c == 4'hF);
    m  = mr || mw;
    cf = (c == 4'hA) || (c == 4'hB);
    tk = (m && !a[0]) || cf;
    ea = !tk ? 30'd0 : cf ? {24'd0, a[7:2]} : a[31:2];
    chk({tag, " claim"},    claim,          tk);
    chk({tag, " is_read"},  is_read,        tk && (mr || (cf && !c[0])));
    chk({tag, " is_config"},is_config,      cf);
    chk({tag, " cur_addr"}, cur_addr,       ea);
    chk({tag, " wrap"},     wrap_mode,      m && a[1:0] == 2'b10);
    chk({tag, " rsv"},      reserved_order, m && a[0]);
    chk("R10 parity",       addr_par,       ^{a, c});
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 claim", claim, 0); chk("R11 cur_addr", cur_addr, 0);
    chk("R11 parity", addr_par, 0); chk("R11 flags", {is_read, is_config, wrap_mode, reserved_order}, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R10 sweep of every command and ordering code
    for (int c = 0; c < 16; c++) begin
      for (int lo = 0; lo < 4; lo++) begin
        logic [31:0] a;
        a = 32'h9E37_79B9 * (c * 4 + lo + 1);
        a[1:0] = lo[1:0];
        addr_phase(c[3:0], a, 1'b0);
        expect_phase("R1_R2_R3_R4_R5", c[3:0], a);
        end_xfer();
        chk("R9 cleared claim", claim, 0);
        chk("R9 cleared addr", cur_addr, 0);
        chk("R9 cleared par", addr_par, 0);
      end
    end

    // R6 linear memory burst wrapping at top of space
    addr_phase(4'h6, 32'hFFFF_FFF8, 1'b0);
    phases(3);
    chk("R6 linear wrap-around", cur_addr, 30'd1);
    // R8 hold without phase_done
    repeat (4) @(negedge clk);
    chk("R8 hold", cur_addr, 30'd1);
    end_xfer();

    // R5 R6 cache-wrap ordering advances linearly
    addr_phase(4'hF, 32'h1000_001A, 1'b0);
    chk("R5 wrap flag", wrap_mode, 1);
    phases(5);
    chk("R6 wrap-mode linear step", cur_addr, 30'h0400_000B);
    end_xfer();

    // R7 configuration index wraps inside 256 bytes
    addr_phase(4'hA, 32'h1234_56FC, 1'b0);
    chk("R7 cfg load", cur_addr, 30'd63);
    phases(2);
    chk("R7 cfg wrap", cur_addr, 30'd1);
    end_xfer();

    // R8 phase_done ignored when unclaimed
    addr_phase(4'hD, 32'h0000_0100, 1'b0);
    phases(4);
    chk("R8 unclaimed no step", cur_addr, 0);
    chk("R4 dual address unclaimed", claim, 0);

    // R9 new address phase wins over same-clock xfer_end
    addr_phase(4'h7, 32'h0000_0040, 1'b1);
    chk("R9 priority claim", claim, 1);
    chk("R9 priority addr", cur_addr, 30'h10);
    phases(1);
    chk("R6 single step", cur_addr, 30'h11);
    end_xfer();
    chk("R9 final clear", {claim, is_read, is_config, wrap_mode, reserved_order}, 0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule